// File: doc/BRIEF.md
# First-Level Interrupt Controller with Encoded Source Reporting

This block gathers 32 interrupt request lines and drives two request outputs to a processor: a normal request and a fast request. Each line passes through a two-stage synchronizer and then sets a bit in a pending register. A line can be edge-triggered or level-triggered. A mask register sits after the pending register, so every request is recorded even while its line is masked. A per-line routing register sends each pending, unmasked line to one of the two outputs.

Software reaches the block over a simple 32-bit register bus with an address, a write strobe, a read strobe and data. For each output, a read-only encoded-source register holds the number of the lowest-numbered line that is currently competing for that output. Reading an encoded-source register also acknowledges the line it reports, but only when that line is edge-triggered. Software clears pending bits by writing zeros to the pending register. Bits written as one keep their value, so one line can be discarded without touching the others.

Top module: `intc_l1`

## Requirements
- R1: After reset the pending register (0x00) reads 0, the mask (0x04) reads 0xFFFFFFFF, the sensitivity (0x08) and routing (0x0C) registers read 0, both encoded-source registers read 0, and `irq_o` and `fiq_o` are low.
- R2: A write to 0x00 clears every pending bit written as 0 and leaves every bit written as 1 unchanged.
- R3: A request sets its pending bit whatever the mask. A mask bit of 1 keeps that line from driving either output or either encoded-source register.
- R4: An edge-triggered line (sensitivity bit 1) sets its pending bit on a rising edge of the synchronized input. An input changed between clock edges shows up in the pending register after the third following rising clock edge, and not after the second.
- R5: A level-triggered line (sensitivity bit 0) sets its pending bit on every cycle its synchronized input is high. While the input stays high, a write of 0 does not clear the bit.
- R6: The encoded-source register at 0x10 serves `irq_o` and the one at 0x14 serves `fiq_o`. Each returns the line number in bits 4:0 and zeros in bits 31:5. It reads 0 when no line competes for that output.
- R7: When several pending, unmasked lines are routed to the same output, the lowest-numbered line is the one reported.
- R8: A read of an encoded-source register clears the pending bit of the reported line if that line is edge-triggered. A level-triggered reported line keeps its pending bit.
- R9: The sensitivity register (0x08, 1 = edge) and the routing register (0x0C, 1 = fast output) can be written and read back.
- R10: `irq_o` is high while any pending, unmasked line has routing bit 0. `fiq_o` is high while any such line has routing bit 1.
- R11: If a new rising edge sets a pending bit in the same cycle that a clear of that bit takes effect, whether by a write of 0 or by an encoded-source read, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_lines_i | input | 32 | Asynchronous interrupt request lines |
| bus_addr_i | input | 8 | Register byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read; the read data is valid in the same cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The critical collision is between the setting of a pending bit by a fresh rising edge and the clearing of that same bit, either by a software write of 0 or by the acknowledge of an encoded-source read. The bench first leaves an edge line pending and lets its input fall. It then raises the input again, with the write strobe, or the read strobe aimed at the normal-output source register, held during the third clock edge after the rise, which is the exact edge on which the rise lands in the pending register. The bench judges the outcome by reading back the pending register, where the bit must still be set. A follow-up acknowledge or write must then clear it, which shows that the clear path itself was not at fault.

// File: rtl/intc_l1_pkg.sv
package intc_l1_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SENSE = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_NSRC  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FSRC  = 8'h14;
endpackage

// File: rtl/intc_l1_sync.sv
module intc_l1_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, stab_q, prev_q;
  logic [W-1:0] meta_d, stab_d, prev_d;

  always_comb begin
    meta_d = async_i;
    stab_d = meta_q;
    prev_d = stab_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
      prev_q <= prev_d;
    end
  end

  assign level_o = stab_q;
  assign rise_o  = stab_q & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)) // R4
    else $error("rise flagged two cycles in a row");
endmodule

// File: rtl/intc_l1_pend.sv
module intc_l1_pend #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q, pend_d, clr_vec;

  always_comb begin
    clr_vec = ack_i;
    if (wr_en_i) clr_vec = clr_vec | ~wr_data_i;
    pend_d = (pend_q & ~clr_vec) | set_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i))) // R11
    else $error("a set request was lost");

  AST_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && ack_i == '0) |=> ((pend_q & $past(pend_q & wr_data_i)) == $past(pend_q & wr_data_i))) // R2
    else $error("a bit written as one was disturbed");
endmodule

// File: rtl/intc_l1_prio.sv
module intc_l1_prio #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [W-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_o |-> (req_i[idx_o] && ((req_i & ~({W{1'b1}} << idx_o)) == '0))) // R7
    else $error("winner is not the lowest requester");
endmodule

// File: rtl/intc_l1.sv
module intc_l1
  import intc_l1_pkg::*;
#(
  parameter int NUM_LINES = 32,
  localparam int IW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 irq_o,
  output logic                 fiq_o
);
  // reset synchronizer: asserted at once, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  // configuration registers
  logic [NUM_LINES-1:0] mask_q, mask_d, sense_q, sense_d, route_q, route_d;
  logic mask_en, sense_en, route_en, pend_wr;
  logic [NUM_LINES-1:0] wdata_lines;

  assign wdata_lines = bus_wdata_i[NUM_LINES-1:0];

  always_comb begin
    mask_en  = bus_wr_i && (bus_addr_i == OFS_MASK);
    sense_en = bus_wr_i && (bus_addr_i == OFS_SENSE);
    route_en = bus_wr_i && (bus_addr_i == OFS_ROUTE);
    pend_wr  = bus_wr_i && (bus_addr_i == OFS_PEND);
    mask_d   = mask_en  ? wdata_lines : mask_q;
    sense_d  = sense_en ? wdata_lines : sense_q;
    route_d  = route_en ? wdata_lines : route_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      sense_q <= '0;
      route_q <= '0;
    end else begin
      mask_q  <= mask_d;
      sense_q <= sense_d;
      route_q <= route_d;
    end
  end

  // input capture
  logic [NUM_LINES-1:0] lvl, rise, set_vec, pend, ack_vec;

  intc_l1_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .async_i(irq_lines_i),
    .level_o(lvl), .rise_o(rise)
  );

  assign set_vec = (sense_q & rise) | (~sense_q & lvl);

  intc_l1_pend #(.W(NUM_LINES)) u_pend (
    .clk(clk), .rst_ni(rst_ni), .set_i(set_vec),
    .wr_en_i(pend_wr), .wr_data_i(wdata_lines),
    .ack_i(ack_vec), .pend_o(pend)
  );

  // arbitration per output
  localparam int NOUT = 2;
  logic [NOUT-1:0]          win_valid;
  logic [NOUT-1:0][IW-1:0]  win_idx;
  logic [NOUT-1:0]          src_rd;
  logic [NUM_LINES-1:0]     active;

  assign active = pend & ~mask_q;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    logic [NUM_LINES-1:0] req;
    assign req = (g == 0) ? (active & ~route_q) : (active & route_q);
    intc_l1_prio #(.W(NUM_LINES)) u_prio (
      .clk(clk), .rst_ni(rst_ni), .req_i(req),
      .valid_o(win_valid[g]), .idx_o(win_idx[g])
    );
  end

  assign src_rd[0] = bus_rd_i && (bus_addr_i == OFS_NSRC);
  assign src_rd[1] = bus_rd_i && (bus_addr_i == OFS_FSRC);

  always_comb begin
    ack_vec = '0;
    for (int o = 0; o < NOUT; o++) begin
      if (src_rd[o] && win_valid[o])
        ack_vec = ack_vec | (NUM_LINES'(1) << win_idx[o]);
    end
    ack_vec = ack_vec & sense_q;
  end

  assign irq_o = win_valid[0];
  assign fiq_o = win_valid[1];

  // read data
  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      case (bus_addr_i)
        OFS_PEND:  bus_rdata_o = DATA_W'(pend);
        OFS_MASK:  bus_rdata_o = DATA_W'(mask_q);
        OFS_SENSE: bus_rdata_o = DATA_W'(sense_q);
        OFS_ROUTE: bus_rdata_o = DATA_W'(route_q);
        OFS_NSRC:  bus_rdata_o = DATA_W'(win_idx[0]);
        OFS_FSRC:  bus_rdata_o = DATA_W'(win_idx[1]);
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    (&mask_q) |-> (!irq_o && !fiq_o)) // R3
    else $error("request output while all lines masked");

  AST_SRC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (src_rd != '0) |-> (bus_rdata_o[DATA_W-1:IW] == '0)) // R6
    else $error("encoded source has upper bits set");

  AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    (src_rd[0] && irq_o && sense_q[win_idx[0]] && !set_vec[win_idx[0]])
      |=> !pend[$past(win_idx[0])]) // R8
    else $error("edge line not acknowledged by source read");

  AST_LEVEL_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_ni)
    (src_rd[0] && irq_o && !sense_q[win_idx[0]] && !pend_wr)
      |=> pend[$past(win_idx[0])]) // R8
    else $error("level line cleared by source read");
endmodule

// File: tb/intc_l1_test.sv
`timescale 1ns/1ps
module intc_l1_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lines;
  logic [7:0]  addr;
  logic        wr, rd;
  logic [31:0] wdata, rdata;
  logic        irq, fiq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intc_l1 uut (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  typedef struct packed {
    logic [31:0] in, mask, sense, route;
    logic [4:0]  nsrc, fsrc;
    logic        io, fo;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0010, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 5'd4,  5'd0,  1'b1, 1'b0},
    '{32'h0000_0300, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0200, 5'd8,  5'd9,  1'b1, 1'b1},
    '{32'h8000_0001, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 5'd31, 5'd0,  1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 5'd0,  5'd0,  1'b0, 1'b0},
    '{32'h00F0_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 5'd0,  5'd20, 1'b0, 1'b1},
    '{32'h0000_0006, 32'h0000_0002, 32'h0000_0000, 32'h0000_0004, 5'd0,  5'd2,  1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; lines = '0; addr = '0; wr = 0; rd = 0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_rd(8'h00, v); chk("R1 pending", v, 32'h0);
    bus_rd(8'h04, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    bus_rd(8'h08, v); chk("R1 sense", v, 32'h0);
    bus_rd(8'h0C, v); chk("R1 route", v, 32'h0);
    bus_rd(8'h10, v); chk("R1 nsrc", v, 32'h0);
    bus_rd(8'h14, v); chk("R1 fsrc", v, 32'h0);
    chk("R1 outputs", {30'b0, irq, fiq}, 32'h0);

    // vector table: R6 R7 R10 R3
    for (int k = 0; k < NV; k++) begin
      bus_wr(8'h04, VECS[k].mask);
      bus_wr(8'h08, VECS[k].sense);
      bus_wr(8'h0C, VECS[k].route);
      @(negedge clk); lines = VECS[k].in;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R10 vec%0d irq_o", k), {31'b0, irq}, {31'b0, VECS[k].io});
      chk($sformatf("R10 vec%0d fiq_o", k), {31'b0, fiq}, {31'b0, VECS[k].fo});
      bus_rd(8'h14, v); chk($sformatf("R7 vec%0d fsrc", k), v, {27'b0, VECS[k].fsrc});
      bus_rd(8'h10, v); chk($sformatf("R6 vec%0d nsrc", k), v, {27'b0, VECS[k].nsrc});
      lines = '0;
      repeat (3) @(posedge clk);
      bus_wr(8'h00, 32'h0);
    end

    // R9 readback
    bus_wr(8'h08, 32'hA5A5_0F0F); bus_rd(8'h08, v); chk("R9 sense rb", v, 32'hA5A5_0F0F);
    bus_wr(8'h0C, 32'h1234_5678); bus_rd(8'h0C, v); chk("R9 route rb", v, 32'h1234_5678);

    // R3 masked occurrence recorded, R4 latency
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_wr(8'h0C, 32'h0);
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_wr(8'h00, 32'h0);
    @(negedge clk); lines = 32'h0000_0020;
    repeat (2) @(posedge clk);
    @(negedge clk);
    addr = 8'h00; rd = 1'b1; #1 chk("R4 not after two edges", rdata, 32'h0);
    @(posedge clk); @(negedge clk); #1 chk("R4 after third edge", rdata, 32'h20);
    rd = 1'b0;
    chk("R3 masked no irq_o", {31'b0, irq}, 32'h0);
    bus_rd(8'h10, v); chk("R3 masked nsrc", v, 32'h0);
    bus_wr(8'h04, 32'h0);
    #1 chk("R3 unmask irq_o", {31'b0, irq}, 32'h1);

    // R2 write one keeps, zero clears
    lines = '0;
    bus_wr(8'h00, 32'hFFFF_FFFF); bus_rd(8'h00, v); chk("R2 ones keep", v, 32'h20);
    bus_wr(8'h00, 32'hFFFF_FFDF); bus_rd(8'h00, v); chk("R2 zero clears", v, 32'h0);

    // R8 edge acknowledged by read
    @(negedge clk); lines = 32'h0000_0020;
    repeat (3) @(posedge clk);
    bus_rd(8'h10, v); chk("R8 edge nsrc", v, 32'd5);
    bus_rd(8'h00, v); chk("R8 edge cleared", v, 32'h0);
    lines = '0;
    repeat (3) @(posedge clk);

    // R5 level held, R8 level kept
    bus_wr(8'h08, 32'hFFFF_FFBF);
    @(negedge clk); lines = 32'h0000_0040;
    repeat (3) @(posedge clk);
    bus_wr(8'h00, 32'h0); bus_rd(8'h00, v); chk("R5 level survives clear", v, 32'h40);
    bus_rd(8'h10, v); chk("R8 level nsrc", v, 32'd6);
    bus_rd(8'h00, v); chk("R8 level kept", v, 32'h40);
    lines = '0;
    repeat (3) @(posedge clk);
    bus_wr(8'h00, 32'h0); bus_rd(8'h00, v); chk("R5 cleared after drop", v, 32'h0);

    // R11 new edge against write clear
    bus_wr(8'h08, 32'hFFFF_FFFF);
    @(negedge clk); lines = 32'h0000_0080;
    repeat (3) @(posedge clk);
    @(negedge clk); lines = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); lines = 32'h0000_0080;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 8'h00; wdata = 32'h0; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    bus_rd(8'h00, v); chk("R11 edge beats write", v, 32'h80);
    bus_wr(8'h00, 32'h0); bus_rd(8'h00, v); chk("R11 later write clears", v, 32'h0);

    // R11 new edge against read acknowledge
    @(negedge clk); lines = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); lines = 32'h0000_0080;
    repeat (3) @(posedge clk);
    @(negedge clk); lines = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); lines = 32'h0000_0080;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 8'h10; rd = 1'b1;
    #1 chk("R11 nsrc at collision", rdata, 32'd7);
    @(negedge clk); rd = 1'b0;
    bus_rd(8'h00, v); chk("R11 edge beats ack", v, 32'h80);
    bus_rd(8'h10, v); chk("R8 second ack nsrc", v, 32'd7);
    bus_rd(8'h00, v); chk("R8 second ack clears", v, 32'h0);

    summary();
  end
endmodule